// File: doc/BRIEF.md
# Interlace-Capable Display Timing Generator

This block produces the raster strobes for one display channel: horizontal sync, vertical sync, a data-enable strobe for visible pixels, a blanking strobe, a field identifier and a one-cycle frame-start pulse. It runs on an externally supplied pixel clock. Each line is laid out as sync, back porch, active region and front porch. Each field is laid out the same way in lines. The horizontal and vertical sizes come from registers that software writes through a small synchronous write/read port.

In progressive mode every frame uses the first-field vertical timing. In interlaced mode the generator alternates between a first and a second field. The second field has its own vertical timing word and its own active-line count, so it can run one extra back-porch line. Timing words and the scan mode are held in a shadow copy. A write made while the raster runs therefore changes nothing until the next first-field start. The run bit, both sync polarities and the interrupt mask act at once. A frame-start status flag, gated by the mask, drives the interrupt output and is cleared by writing a one to it.

All timing fields are stored as the count minus one. With the default counter width of 10 bits, every stored value lies in 0..1023.

Top module: `scan_timing_gen`

## Requirements
- R1: While the run bit (address 0, bit 0) is 0, the counters rest at zero: data-enable, blanking, field and frame-start are 0, and each sync output sits at its inactive level.
- R2: A line lasts (hs+1)+(hb+1)+(ha+1)+(hf+1) clocks. Horizontal sync is active for the first hs+1 clocks of the line. These fields are: sync hs in address 1 bits 9:0, back porch hb in bits 19:10, front porch hf in bits 29:20, and active width ha in address 4 bits 9:0.
- R3: Data-enable is high for exactly ha+1 clocks in each active line, starting hs+hb+2 clocks after the line start. It is never high during a sync pulse.
- R4: A field lasts (vs+1)+(vb+1)+(va+1)+(vf+1) lines. Vertical sync covers its first vs+1 lines and the active lines follow sync and back porch. First-field timing uses address 2 (same layout as address 1) and va in address 4 bits 19:10.
- R5: When the interlace bit (address 0, bit 1) is set, fields alternate first, second, first. The field output is 1 during the second field, which uses the timing word at address 3 and the active count at address 5 bits 9:0. In progressive mode the field output stays 0.
- R6: Address 0 bit 2 makes horizontal sync active-low, and bit 3 does the same for vertical sync. Both take effect on the cycle after the write.
- R7: The frame-start output pulses for one clock at the first pixel of every field or frame.
- R8: With the mask bit (address 0, bit 4) set, a frame start sets the status flag (address 6, bit 0), which drives the interrupt output. Writing 1 to that bit clears it and writing 0 leaves it. With the mask clear, the flag is not set.
- R9: Timing words and the interlace bit written while running take effect only at the next first-field start.
- R10: Reads return the written value of each register, limited to its defined bits, one clock after the read request. Address 7 reads zero.
- R11: Blanking is high exactly when running and data-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Read data, valid the clock after rd_en |
| hsync_o | output | 1 | Horizontal sync with programmed polarity |
| vsync_o | output | 1 | Vertical sync with programmed polarity |
| de_o | output | 1 | Active-video strobe |
| blank_o | output | 1 | Blanking strobe |
| field_o | output | 1 | 1 during the second interlaced field |
| frame_start_o | output | 1 | One-clock pulse at each field or frame start |
| irq_o | output | 1 | Frame interrupt (masked status flag) |

## Verification
The raster is tried first with a small directed progressive layout and then with a narrow interlaced layout whose second field is one line longer. Together these separate a wrong porch order, a missing minus-one adjustment and a field that wrongly reuses the first-field timing. Seeded random layouts, with a random polarity pair and interlace choice, then vary each field independently, so that swapped or mis-positioned bit fields show up as timing mismatches. Directed writes in the middle of a frame, a runtime polarity flip and status writes of 0 and 1 separate deferred from immediate register effects and write-one-to-clear from plain write.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

   localparam int REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL   = 3'd0,
      REG_HTIME  = 3'd1,
      REG_VTIME1 = 3'd2,
      REG_VTIME2 = 3'd3,
      REG_SIZE   = 3'd4,
      REG_VACT2  = 3'd5,
      REG_STATUS = 3'd6,
      REG_SPARE  = 3'd7
   } reg_addr_e;

   localparam int CTRL_RUN   = 0;
   localparam int CTRL_ILACE = 1;
   localparam int CTRL_HLOW  = 2;
   localparam int CTRL_VLOW  = 3;
   localparam int CTRL_IRQEN = 4;
   localparam int CTRL_BITS  = 5;

endpackage

// File: rtl/stg_regfile.sv
module stg_regfile
   import scan_timing_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   input  logic                  rd_en_i,
   input  logic [REG_ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0]     rd_data_o,
   input  logic                  load_i,
   input  logic                  frame_start_i,
   output logic                  run_o,
   output logic                  hlow_o,
   output logic                  vlow_o,
   output logic                  irq_en_o,
   output logic                  irq_o,
   output logic                  sh_ilace_o,
   output logic [3*CNT_W-1:0]    sh_htime_o,
   output logic [3*CNT_W-1:0]    sh_vt1_o,
   output logic [3*CNT_W-1:0]    sh_vt2_o,
   output logic [2*CNT_W-1:0]    sh_size_o,
   output logic [CNT_W-1:0]      sh_vact2_o
);
   localparam int TW = 3 * CNT_W;
   localparam int SW = 2 * CNT_W;

   logic [CTRL_BITS-1:0] ctrl_q;
   logic [TW-1:0]        htime_q, vt1_q, vt2_q;
   logic [SW-1:0]        size_q;
   logic [CNT_W-1:0]     vact2_q;
   logic                 status_q;
   logic [DATA_W-1:0]    rd_mux, rd_q;
   logic                 unused_wdata;

   assign unused_wdata = ^wr_data_i;

   // live registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         htime_q <= '0;
         vt1_q   <= '0;
         vt2_q   <= '0;
         size_q  <= '0;
         vact2_q <= '0;
      end else if (wr_en_i) begin
         case (reg_addr_e'(wr_addr_i))
            REG_CTRL:   ctrl_q  <= wr_data_i[CTRL_BITS-1:0];
            REG_HTIME:  htime_q <= wr_data_i[TW-1:0];
            REG_VTIME1: vt1_q   <= wr_data_i[TW-1:0];
            REG_VTIME2: vt2_q   <= wr_data_i[TW-1:0];
            REG_SIZE:   size_q  <= wr_data_i[SW-1:0];
            REG_VACT2:  vact2_q <= wr_data_i[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // frame-start flag: a new start wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= 1'b0;
      else if (frame_start_i && ctrl_q[CTRL_IRQEN])
         status_q <= 1'b1;
      else if (wr_en_i && reg_addr_e'(wr_addr_i) == REG_STATUS && wr_data_i[0])
         status_q <= 1'b0;
   end

   // shadow copy used by the counters
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ilace_o <= 1'b0;
         sh_htime_o <= '0;
         sh_vt1_o   <= '0;
         sh_vt2_o   <= '0;
         sh_size_o  <= '0;
         sh_vact2_o <= '0;
      end else if (load_i) begin
         sh_ilace_o <= ctrl_q[CTRL_ILACE];
         sh_htime_o <= htime_q;
         sh_vt1_o   <= vt1_q;
         sh_vt2_o   <= vt2_q;
         sh_size_o  <= size_q;
         sh_vact2_o <= vact2_q;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr_e'(rd_addr_i))
         REG_CTRL:   rd_mux[CTRL_BITS-1:0] = ctrl_q;
         REG_HTIME:  rd_mux[TW-1:0]        = htime_q;
         REG_VTIME1: rd_mux[TW-1:0]        = vt1_q;
         REG_VTIME2: rd_mux[TW-1:0]        = vt2_q;
         REG_SIZE:   rd_mux[SW-1:0]        = size_q;
         REG_VACT2:  rd_mux[CNT_W-1:0]     = vact2_q;
         REG_STATUS: rd_mux[0]             = status_q;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en_i)
         rd_q <= rd_mux;
   end

   assign rd_data_o = rd_q;
   assign run_o     = ctrl_q[CTRL_RUN];
   assign hlow_o    = ctrl_q[CTRL_HLOW];
   assign vlow_o    = ctrl_q[CTRL_VLOW];
   assign irq_en_o  = ctrl_q[CTRL_IRQEN];
   assign irq_o     = status_q;

endmodule

// File: rtl/stg_axis.sv
module stg_axis #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] sync_m1_i,
   input  logic [CNT_W-1:0] back_m1_i,
   input  logic [CNT_W-1:0] act_m1_i,
   input  logic [CNT_W-1:0] front_m1_i,
   output logic             wrap_o,
   output logic             zero_o,
   output logic             in_sync_o,
   output logic             in_act_o
);
   localparam int POS_W = CNT_W + 2;

   logic [POS_W-1:0] pos_q, act_lo, act_hi, last_pos;
   logic             at_last;

   // position layout: sync, back porch, active, front porch
   always_comb begin
      act_lo   = POS_W'(sync_m1_i) + POS_W'(back_m1_i) + POS_W'(2);
      act_hi   = act_lo + POS_W'(act_m1_i) + POS_W'(1);
      last_pos = act_hi + POS_W'(front_m1_i);
   end

   assign at_last = (pos_q == last_pos);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (!run_i)
         pos_q <= '0;
      else if (step_i)
         pos_q <= at_last ? '0 : pos_q + POS_W'(1);
   end

   assign wrap_o    = run_i & step_i & at_last;
   assign zero_o    = (pos_q == '0);
   assign in_sync_o = (pos_q <= POS_W'(sync_m1_i));
   assign in_act_o  = (pos_q >= act_lo) && (pos_q < act_hi);

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
   import scan_timing_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  hsync_o,
   output logic                  vsync_o,
   output logic                  de_o,
   output logic                  blank_o,
   output logic                  field_o,
   output logic                  frame_start_o,
   output logic                  irq_o
);
   localparam int TW    = 3 * CNT_W;
   localparam int SW    = 2 * CNT_W;
   localparam int STG_W = 11;

   if (TW > DATA_W) begin : g_bad_width
      $error("scan_timing_gen: DATA_W must hold three timing fields");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("scan_timing_gen: CNT_W must be at least 2");
   end

   logic run, hlow, vlow, irq_en, irq_raw, sh_ilace, load, field_q, frame_start;
   logic [TW-1:0]    sh_htime, sh_vt1, sh_vt2, vt_sel;
   logic [SW-1:0]    sh_size;
   logic [CNT_W-1:0] sh_vact2, vact_sel;
   logic h_wrap, h_zero, h_sync, h_act, v_wrap, v_zero, v_sync, v_act;
   logic de_raw;
   logic [STG_W-1:0] stg_in, stg_out;
   logic run_v, hlow_v, vlow_v, irqen_v;

   stg_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .load_i(load), .frame_start_i(frame_start),
      .run_o(run), .hlow_o(hlow), .vlow_o(vlow), .irq_en_o(irq_en), .irq_o(irq_raw),
      .sh_ilace_o(sh_ilace), .sh_htime_o(sh_htime), .sh_vt1_o(sh_vt1),
      .sh_vt2_o(sh_vt2), .sh_size_o(sh_size), .sh_vact2_o(sh_vact2)
   );

   stg_axis #(.CNT_W(CNT_W)) u_hor (
      .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(1'b1),
      .sync_m1_i(sh_htime[CNT_W-1:0]), .back_m1_i(sh_htime[SW-1:CNT_W]),
      .act_m1_i(sh_size[CNT_W-1:0]), .front_m1_i(sh_htime[TW-1:SW]),
      .wrap_o(h_wrap), .zero_o(h_zero), .in_sync_o(h_sync), .in_act_o(h_act)
   );

   assign vt_sel   = field_q ? sh_vt2 : sh_vt1;
   assign vact_sel = field_q ? sh_vact2 : sh_size[SW-1:CNT_W];

   stg_axis #(.CNT_W(CNT_W)) u_ver (
      .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(h_wrap),
      .sync_m1_i(vt_sel[CNT_W-1:0]), .back_m1_i(vt_sel[SW-1:CNT_W]),
      .act_m1_i(vact_sel), .front_m1_i(vt_sel[TW-1:SW]),
      .wrap_o(v_wrap), .zero_o(v_zero), .in_sync_o(v_sync), .in_act_o(v_act)
   );

   // field sequencing; shadow reload when idle or before a first field
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         field_q <= 1'b0;
      else if (!run)
         field_q <= 1'b0;
      else if (v_wrap)
         field_q <= sh_ilace & ~field_q;
   end

   assign load        = ~run | (v_wrap & (field_q | ~sh_ilace));
   assign frame_start = run & h_zero & v_zero;
   assign de_raw      = run & h_act & v_act;

   assign stg_in = {irq_en, vlow, hlow, run, irq_raw, frame_start, run & field_q,
                    run & ~de_raw, de_raw, (run & v_sync) ^ vlow, (run & h_sync) ^ hlow};

   if (REG_OUT) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stg_out <= '0;
         else
            stg_out <= stg_in;
      end
   end else begin : g_out_comb
      assign stg_out = stg_in;
   end

   assign {irqen_v, vlow_v, hlow_v, run_v, irq_o, frame_start_o, field_o,
           blank_o, de_o, vsync_o, hsync_o} = stg_out;

endmodule

// File: rtl/stg_checker.sv
module stg_checker (
   input logic clk,
   input logic rst_n,
   input logic run_v,
   input logic hlow_v,
   input logic vlow_v,
   input logic irqen_v,
   input logic hsync_o,
   input logic vsync_o,
   input logic de_o,
   input logic blank_o,
   input logic field_o,
   input logic frame_start_o,
   input logic irq_o
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v |-> (!de_o && !blank_o && !field_o && !frame_start_o &&
                  hsync_o == hlow_v && vsync_o == vlow_v))
      else $error("idle outputs not inactive");

   assert_de_clear_of_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      de_o |-> (hsync_o == hlow_v && vsync_o == vlow_v))
      else $error("data-enable overlaps sync");

   assert_field_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v && $past(run_v) && field_o != $past(field_o)) |-> frame_start_o)
      else $error("field changed away from a field start");

   assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> !frame_start_o)
      else $error("frame start longer than one clock");

   assert_irq_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start_o && irqen_v) |=> irq_o)
      else $error("masked frame start did not raise interrupt");

   assert_blank_excludes_de_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(blank_o && de_o))
      else $error("blank and data-enable together");

endmodule

bind scan_timing_gen stg_checker u_stg_checker (
   .clk(clk), .rst_n(rst_n), .run_v(run_v), .hlow_v(hlow_v), .vlow_v(vlow_v),
   .irqen_v(irqen_v), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
   .blank_o(blank_o), .field_o(field_o), .frame_start_o(frame_start_o), .irq_o(irq_o)
);

// File: tb/scan_timing_gen_bench.sv
`timescale 1ns/1ps
module scan_timing_gen_bench;
   localparam int CNT_W  = 10;
   localparam int DATA_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic hsync_o, vsync_o, de_o, blank_o, field_o, frame_start_o, irq_o;

   always #2 clk = ~clk;

   scan_timing_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_scan_timing_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .blank_o(blank_o),
      .field_o(field_o), .frame_start_o(frame_start_o), .irq_o(irq_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   // model: 0 hs,1 hb,2 ha,3 hf,4..7 field1 v,8..11 field2 v,12 interlace
   int pend[13];
   int cur[13];
   int mh, mv, mf;
   bit men, hpol, vpol;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   function automatic logic [31:0] tw(input int s, input int b, input int f);
      return 32'(s) | (32'(b) << 10) | (32'(f) << 20);
   endfunction

   function automatic logic [31:0] rmask(input int a);
      case (a)
         0: return 32'h1F;
         1, 2, 3: return 32'h3FFF_FFFF;
         4: return 32'h000F_FFFF;
         5: return 32'h3FF;
         default: return 32'h0;
      endcase
   endfunction

   function automatic void model_write(input int a, input logic [31:0] d);
      case (a)
         0: begin men = d[0]; pend[12] = int'(d[1]); hpol = d[2]; vpol = d[3]; end
         1: begin pend[0] = int'(d[9:0]); pend[1] = int'(d[19:10]); pend[3] = int'(d[29:20]); end
         2: begin pend[4] = int'(d[9:0]); pend[5] = int'(d[19:10]); pend[7] = int'(d[29:20]); end
         3: begin pend[8] = int'(d[9:0]); pend[9] = int'(d[19:10]); pend[11] = int'(d[29:20]); end
         4: begin pend[2] = int'(d[9:0]); pend[6] = int'(d[19:10]); end
         5: pend[10] = int'(d[9:0]);
         default: ;
      endcase
   endfunction

   function automatic logic [5:0] expect_vec();
      int vb;
      bit hs, ha, vs, va, de;
      vb = (mf != 0) ? 8 : 4;
      hs = mh < cur[0] + 1;
      ha = (mh >= cur[0] + cur[1] + 2) && (mh < cur[0] + cur[1] + cur[2] + 3);
      vs = mv < cur[vb] + 1;
      va = (mv >= cur[vb] + cur[vb+1] + 2) && (mv < cur[vb] + cur[vb+1] + cur[vb+2] + 3);
      de = ha && va;
      return {(mh == 0 && mv == 0), (mf != 0), !de, de, vs ^ vpol, hs ^ hpol};
   endfunction

   function automatic void step();
      int htot, vtot, vb, nf;
      if (!men) begin
         cur = pend; mh = 0; mv = 0; mf = 0;
         return;
      end
      htot = cur[0] + cur[1] + cur[2] + cur[3] + 4;
      if (mh == htot - 1) begin
         mh = 0;
         vb = (mf != 0) ? 8 : 4;
         vtot = cur[vb] + cur[vb+1] + cur[vb+2] + cur[vb+3] + 4;
         if (mv == vtot - 1) begin
            mv = 0;
            nf = (cur[12] != 0) ? ((mf != 0) ? 0 : 1) : 0;
            if (nf == 0) cur = pend;
            mf = nf;
         end else begin
            mv++;
         end
      end else begin
         mh++;
      end
   endfunction

   // all tasks start and end at a falling edge
   task automatic wr(input int a, input logic [31:0] d);
      bit old_en;
      old_en = men;
      wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (!old_en) cur = pend;
      model_write(a, d);
      if (men && !old_en) begin mh = 0; mv = 0; mf = 0; end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_en = 1'b1; rd_addr = a[2:0];
      @(negedge clk);
      rd_en = 1'b0;
      if (!men) cur = pend;
      d = rd_data;
   endtask

   task automatic run_check(input string tag, input int n, input int wa,
                            input logic [31:0] wd, input int wat);
      int mis[6];
      logic [5:0] ev, av;
      foreach (mis[i]) mis[i] = 0;
      for (int c = 0; c < n; c++) begin
         ev = expect_vec();
         av = {frame_start_o, field_o, blank_o, de_o, vsync_o, hsync_o};
         for (int s = 0; s < 6; s++) if (av[s] !== ev[s]) mis[s]++;
         if (c == wat) begin wr_en = 1'b1; wr_addr = wa[2:0]; wr_data = wd; end
         else wr_en = 1'b0;
         step();
         if (c == wat) model_write(wa, wd);
         @(negedge clk);
      end
      wr_en = 1'b0;
      chk(mis[0] == 0, {tag, " R2 R6 hsync mismatches"}, mis[0], 0);
      chk(mis[1] == 0, {tag, " R4 R6 vsync mismatches"}, mis[1], 0);
      chk(mis[2] == 0, {tag, " R3 de mismatches"}, mis[2], 0);
      chk(mis[3] == 0, {tag, " R11 blank mismatches"}, mis[3], 0);
      chk(mis[4] == 0, {tag, " R5 field mismatches"}, mis[4], 0);
      chk(mis[5] == 0, {tag, " R7 frame_start mismatches"}, mis[5], 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         finish_sim();
      end
   end

   initial begin
      logic [31:0] q, d;
      int c0;
      void'($urandom(32'h5EED_0A17));
      foreach (pend[i]) begin pend[i] = 0; cur[i] = 0; end
      mh = 0; mv = 0; mf = 0; men = 0; hpol = 0; vpol = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(hsync_o == 1'b0, "R1 hsync after reset", int'(hsync_o), 0);
      chk(vsync_o == 1'b0, "R1 vsync after reset", int'(vsync_o), 0);
      chk(de_o == 1'b0 && blank_o == 1'b0, "R1 de/blank after reset", int'({de_o, blank_o}), 0);
      chk(field_o == 1'b0 && frame_start_o == 1'b0, "R1 field/start after reset",
          int'({field_o, frame_start_o}), 0);
      chk(irq_o == 1'b0, "R8 irq after reset", int'(irq_o), 0);
      rd(6, q);
      chk(q == 32'h0, "R10 status after reset", int'(q), 0);

      // R10 readback of every address with random data
      for (int a = 0; a < 8; a++) begin
         if (a == 6) continue;
         d = $urandom();
         if (a == 0) d[0] = 1'b0;
         wr(a, d);
         rd(a, q);
         chk(q == (d & rmask(a)), "R10 readback", int'(q), int'(d & rmask(a)));
      end

      // R1 R6 idle with both polarities active-low
      wr(0, 32'h0C);
      repeat (20) @(negedge clk);
      chk(hsync_o == 1'b1, "R1 R6 idle hsync inactive-high", int'(hsync_o), 1);
      chk(vsync_o == 1'b1, "R1 R6 idle vsync inactive-high", int'(vsync_o), 1);
      chk({de_o, blank_o, field_o, frame_start_o} == 4'b0, "R1 idle strobes",
          int'({de_o, blank_o, field_o, frame_start_o}), 0);

      // directed progressive raster, mask on
      wr(1, tw(1, 1, 0));
      wr(4, 32'(3) | (32'(2) << 10));
      wr(2, tw(0, 1, 0));
      wr(0, 32'h10);
      wr(0, 32'h11);
      run_check("progressive", 150, -1, 32'h0, -1);
      // R6 runtime polarity flip
      run_check("polarity", 100, 0, 32'h1D, 20);
      // R9 mid-frame timing change deferred to next frame start
      run_check("R9 deferred", 220, 1, tw(0, 2, 1), 7);
      c0 = mh;
      wr(0, 32'h1C);
      chk({de_o, blank_o, field_o, frame_start_o} == 4'b0, "R1 strobes right after stop",
          int'({de_o, blank_o, field_o, frame_start_o}), 0);
      chk(hsync_o == 1'b1 && vsync_o == 1'b1, "R1 R6 syncs right after stop",
          int'({hsync_o, vsync_o}), 3);

      // R8 status flag and write-one-to-clear
      chk(irq_o == 1'b1, "R8 irq set by frame start", int'(irq_o), 1);
      rd(6, q);
      chk(q == 32'h1, "R8 status reads set", int'(q), 1);
      wr(6, 32'h0);
      chk(irq_o == 1'b1, "R8 write 0 keeps status", int'(irq_o), 1);
      wr(6, 32'h1);
      chk(irq_o == 1'b0, "R8 write 1 clears status", int'(irq_o), 0);
      rd(6, q);
      chk(q == 32'h0, "R8 status reads clear", int'(q), 0);

      // directed interlace, second field one back-porch line longer, mask off
      wr(1, tw(0, 1, 0));
      wr(4, 32'(2) | (32'(2) << 10));
      wr(2, tw(0, 1, 0));
      wr(3, tw(0, 2, 0));
      wr(5, 32'd2);
      wr(0, 32'h02);
      wr(0, 32'h03);
      run_check("interlace", 330, -1, 32'h0, -1);
      chk(irq_o == 1'b0, "R8 mask off leaves status clear", int'(irq_o), 0);
      wr(0, 32'h02);

      // seeded random layouts
      for (int it = 0; it < 6; it++) begin
         int vs, vb, vf;
         logic [31:0] ctl;
         vs = $urandom_range(0, 2); vb = $urandom_range(0, 3); vf = $urandom_range(0, 2);
         wr(1, tw($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)));
         wr(4, 32'($urandom_range(0, 7)) | (32'($urandom_range(0, 7)) << 10));
         wr(2, tw(vs, vb, vf));
         wr(3, tw(vs, vb + 1, vf));
         wr(5, 32'($urandom_range(0, 7)));
         ctl = {27'd0, 1'b1, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'b0};
         wr(0, ctl);
         wr(0, ctl | 32'h1);
         run_check("R9 random", 500, 1,
                   tw($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
                   $urandom_range(0, 400));
         wr(0, ctl);
      end

      done = 1'b1;
      finish_sim();
   end

endmodule